// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

This block watches a memory controller through single-cycle event pulses and counts the ones that software picks. It has four counters, each with a control word and a value word, behind a small word-addressed register port. Counter 0 has no event select. It counts controller clock cycles and sets the time base for the whole bank. While it is stopped or has wrapped, the other counters hold their values. When it wraps, the bank raises a level interrupt.

Counters 1 to 3 each take an event code. The code is an index into the event pulse bus. Typical codes are 0x04 for read accesses, 0x05 for write accesses, 0x21 for write commands, 0x32 for activates and 0x37 for refreshes. A general counter wraps without any notice. Counter 0 is cleared by writing its clear bit low and then high. A general counter is cleared by writing its clear bit low, and that bit then reads back high again.

Top module: `ddr_evt_mon`

## Requirements
- R1: After reset every count is 0, `irq` is low, control word 0 reads 0x00000000 and control words 1 to 3 read 0x00000002.
- R2: Control word n sits at byte address 4*n and value word n at 0x20+4*n. Read data appears on `reg_rdata` in the cycle after the read strobe. Unmapped or misaligned addresses read 0, and writes to them are ignored.
- R3: In a control word, bit 0 is overflow (read-only), bit 1 is clear, bit 2 is enable and bits 31:24 are the event code. All other bits read 0.
- R4: Counter 0 adds one on every clock in which it is enabled and its overflow bit is low. Its event code always reads 0, whatever is written.
- R5: Counter n (n ≥ 1) adds one on a clock in which all of these hold: it is enabled, counter 0 is enabled with overflow low, and `evt_pulse[code]` is high. Code 0 and codes ≥ NUM_EVT count nothing.
- R6: Counter 0's clear bit holds the written value. A write that sets the clear bit while the stored bit is 0 zeroes count 0 and its overflow bit.
- R7: For counter n ≥ 1, writing the clear bit as 0 zeroes the count and the bit still reads 1. Writing it as 1 has no effect on the count.
- R8: When counter 0 passes its maximum it wraps to 0 and sets its overflow bit. Counter 0 and all other counters then hold their values.
- R9: `irq` equals counter 0's overflow bit. It stays high until the R6 clear sequence.
- R10: A general counter that passes its maximum wraps to 0, keeps counting and does not touch `irq`.
- R11: While counter 0 is disabled, all counters hold their values. Enabling it again resumes counting, and the enable alone does not clear anything.
- R12: Writes to value words have no effect. If a clear and an increment fall in the same cycle, the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt_pulse | input | NUM_EVT | Event pulses; bit k carries event code k |
| irq | output | 1 | Level interrupt on cycle-counter wrap |

## Verification
The bench builds the block with CNT_W=8 and NUM_EVT=40. With 8-bit counters, counter 0 wraps after 256 cycles and a general counter fed every cycle wraps soon after, so overflow, freeze, interrupt hold and silent wrap all happen within a short run. The 40-wide event bus makes code 0x37 (refresh) fall outside the bus, so the test can show that an out-of-range code counts nothing. A behavioural model compares the interrupt on every clock and checks every read against its expected value.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 6;
    localparam int SEL_W   = 8;
    localparam int BIT_OVF = 0;
    localparam int BIT_CLR = 1;
    localparam int BIT_EN  = 2;
    localparam int SEL_LSB = 24;

    typedef enum logic [1:0] {
        RGN_CTL  = 2'd0,
        RGN_CNT  = 2'd1,
        RGN_NONE = 2'd2
    } rgn_e;

    typedef struct packed {
        rgn_e       rgn;
        logic [2:0] idx;
    } dec_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
        logic             clr;
        logic             ovf;
    } ctl_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a, input int ncnt);
        dec_t d;
        d.idx = a[4:2];
        d.rgn = RGN_NONE;
        if (a[1:0] == 2'b00 && int'(a[4:2]) < ncnt)
            d.rgn = a[5] ? RGN_CNT : RGN_CTL;
        return d;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(input ctl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[SEL_LSB +: SEL_W] = c.sel;
        w[BIT_EN]  = c.en;
        w[BIT_CLR] = c.clr;
        w[BIT_OVF] = c.ovf;
        return w;
    endfunction

    function automatic ctl_t unpack_ctl(input logic [REG_W-1:0] w);
        ctl_t c;
        c.sel = w[SEL_LSB +: SEL_W];
        c.en  = w[BIT_EN];
        c.clr = w[BIT_CLR];
        c.ovf = w[BIT_OVF];
        return c;
    endfunction

endpackage

// File: rtl/pmon_addr_dec.sv
module pmon_addr_dec
    import pmon_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CNT-1:0] wr_ctl,
    output logic              rd_en,
    output dec_t              rd_dec
);

    dec_t d;

    always_comb begin
        d      = decode(addr, NUM_CNT);
        rd_dec = d;
        rd_en  = valid & ~we;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_wr
        assign wr_ctl[g] = valid & we & (d.rgn == RGN_CTL) & (int'(d.idx) == g);
    end

endmodule

// File: rtl/pmon_counter.sv
module pmon_counter
    import pmon_pkg::*;
#(
    parameter bit IS_CYCLE = 1'b0,
    parameter int CNT_W    = 32,
    parameter int NUM_EVT  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  ctl_t               wr_f,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               run,
    output ctl_t               ctl_o,
    output logic [CNT_W-1:0]   cnt_o
);

    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             clr_now;
    logic             unused_in;

    assign ctl_o     = ctl_q;
    assign cnt_o     = cnt_q;
    assign unused_in = ^{evt[0], wr_f.ovf};

    if (IS_CYCLE) begin : g_cycle
        logic at_max;
        logic unused_cyc;
        assign unused_cyc = ^{evt, run, wr_f.sel};
        assign at_max  = &cnt_q;
        assign tick    = ctl_q.en & ~ctl_q.ovf;
        assign clr_now = wr & wr_f.clr & ~ctl_q.clr;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q <= '0;
                cnt_q <= '0;
            end else begin
                if (clr_now) begin
                    cnt_q     <= '0;
                    ctl_q.ovf <= 1'b0;
                end else if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (at_max) ctl_q.ovf <= 1'b1;
                end
                if (wr) begin
                    ctl_q.en  <= wr_f.en;
                    ctl_q.clr <= wr_f.clr;
                end
            end
        end
    end else begin : g_event
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int k = 1; k < NUM_EVT; k++)
                if (int'(ctl_q.sel) == k) hit = evt[k];
        end
        assign tick    = ctl_q.en & run & hit;
        assign clr_now = wr & ~wr_f.clr;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q <= '{sel: '0, en: 1'b0, clr: 1'b1, ovf: 1'b0};
                cnt_q <= '0;
            end else begin
                if (clr_now)   cnt_q <= '0;
                else if (tick) cnt_q <= cnt_q + 1'b1;
                if (wr) begin
                    ctl_q.en  <= wr_f.en;
                    ctl_q.sel <= wr_f.sel;
                end
            end
        end

        AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!run && !clr_now) |=> $stable(cnt_q)); // R11
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !clr_now |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R5
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/ddr_evt_mon.sv
module ddr_evt_mon
    import pmon_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_valid,
    input  logic               reg_we,
    input  logic [5:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq
);

    localparam int EXT_W = REG_W - CNT_W;

    logic [NUM_CNT-1:0] wr_ctl;
    logic               rd_en;
    dec_t               rd_dec;
    ctl_t               wr_f;
    ctl_t               ctl_v [NUM_CNT];
    logic [CNT_W-1:0]   cnt_v [NUM_CNT];
    logic               run;
    logic [REG_W-1:0]   rd_val;
    logic [CNT_W-1:0]   cnt0;
    logic               unused_wd;

    assign wr_f      = unpack_ctl(reg_wdata);
    assign unused_wd = ^{reg_wdata[SEL_LSB-1:BIT_EN+1]};
    assign run       = ctl_v[0].en & ~ctl_v[0].ovf;
    assign irq       = ctl_v[0].ovf;
    assign cnt0      = cnt_v[0];

    pmon_addr_dec #(.NUM_CNT(NUM_CNT)) u_dec (
        .valid  (reg_valid),
        .we     (reg_we),
        .addr   (reg_addr),
        .wr_ctl (wr_ctl),
        .rd_en  (rd_en),
        .rd_dec (rd_dec)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pmon_counter #(
            .IS_CYCLE (g == 0),
            .CNT_W    (CNT_W),
            .NUM_EVT  (NUM_EVT)
        ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_ctl[g]),
            .wr_f  (wr_f),
            .evt   (evt_pulse),
            .run   (run),
            .ctl_o (ctl_v[g]),
            .cnt_o (cnt_v[g])
        );
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (int'(rd_dec.idx) == k) begin
                if (rd_dec.rgn == RGN_CTL)      rd_val = pack_ctl(ctl_v[k]);
                else if (rd_dec.rgn == RGN_CNT) rd_val = {{EXT_W{1'b0}}, cnt_v[k]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        reg_rdata <= '0;
        else if (rd_en) reg_rdata <= rd_val;
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ctl[0]) |=> irq); // R9
    AST_IRQ_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ctl[0]) |=> $stable(cnt0)); // R8
    AST_IRQ_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt0 == '0)); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_we && rd_dec.rgn == RGN_NONE) |=> (reg_rdata == '0)); // R2

endmodule

// File: tb/sim_ddr_evt_mon.sv
module sim_ddr_evt_mon;

    localparam int CNT_W   = 8;
    localparam int NUM_EVT = 40;
    localparam int MAXV    = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               reg_valid = 1'b0;
    logic               reg_we = 1'b0;
    logic [5:0]         reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [NUM_EVT-1:0] evt_pulse = '0;
    logic               irq;

    int checks = 0;
    int fails  = 0;
    int evt_mode = 0;
    bit irq_seen = 0;

    always #10 clk = ~clk;

    ddr_evt_mon #(.NUM_CNT(4), .CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u0 (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq(irq)
    );

    // behavioural reference model
    int   m_cnt [4];
    bit   m_en  [4];
    bit   m_clr [4];
    int   m_sel [4];
    bit   m_ovf;
    logic [31:0] m_rexp;
    bit   m_rpend;

    function automatic logic [31:0] model_read(input logic [5:0] a);
        int k;
        logic [31:0] w;
        w = 32'h0;
        k = int'(a[4:2]);
        if (a[1:0] == 2'b00 && k < 4) begin
            if (!a[5]) begin
                w[31:24] = 8'(m_sel[k]);
                w[2] = m_en[k];
                w[1] = m_clr[k];
                w[0] = (k == 0) ? m_ovf : 1'b0;
            end else begin
                w = 32'(m_cnt[k]);
            end
        end
        return w;
    endfunction

    always @(posedge clk) begin
        int n [4];
        bit nov;
        bit go;
        int k;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_en[i] = 0; m_sel[i] = 0; m_clr[i] = (i != 0);
            end
            m_ovf = 0; m_rpend = 0; m_rexp = 0;
        end else begin
            m_rpend = 0;
            if (reg_valid && !reg_we) begin
                m_rexp = model_read(reg_addr);
                m_rpend = 1;
            end
            for (int i = 0; i < 4; i++) n[i] = m_cnt[i];
            nov = m_ovf;
            go = m_en[0] && !m_ovf;
            if (go) begin
                if (m_cnt[0] == MAXV) begin n[0] = 0; nov = 1; end
                else n[0] = m_cnt[0] + 1;
            end
            for (int i = 1; i < 4; i++)
                if (m_en[i] && go && m_sel[i] > 0 && m_sel[i] < NUM_EVT && evt_pulse[m_sel[i]])
                    n[i] = (m_cnt[i] + 1) % (MAXV + 1);
            if (reg_valid && reg_we && reg_addr[1:0] == 2'b00 && !reg_addr[5] && int'(reg_addr[4:2]) < 4) begin
                k = int'(reg_addr[4:2]);
                if (k == 0) begin
                    if (reg_wdata[1] && !m_clr[0]) begin n[0] = 0; nov = 0; end
                    m_clr[0] = reg_wdata[1];
                    m_en[0] = reg_wdata[2];
                end else begin
                    if (!reg_wdata[1]) n[k] = 0;
                    m_en[k] = reg_wdata[2];
                    m_sel[k] = int'(reg_wdata[31:24]);
                end
            end
            for (int i = 0; i < 4; i++) m_cnt[i] = n[i];
            m_ovf = nov;
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (irq !== m_ovf) begin
                fails++;
                $display("FAIL R9 irq actual=%0b expected=%0b t=%0t", irq, m_ovf, $time);
            end
            if (irq) irq_seen = 1;
            if (m_rpend) begin
                checks++;
                if (reg_rdata !== m_rexp) begin
                    fails++;
                    $display("FAIL R2 read actual=%08h expected=%08h t=%0t", reg_rdata, m_rexp, $time);
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (evt_mode == 1) evt_pulse = '1;
            else evt_pulse = NUM_EVT'({$urandom, $urandom});
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        logic [31:0] v, a, b;
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rd(6'h00, v); chk("R1 ctl0", v, 32'h0000_0000);
        rd(6'h04, v); chk("R1 ctl1", v, 32'h0000_0002);
        rd(6'h20, v); chk("R1 cnt0", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // configure: R4 select ignored on counter 0, R3 field layout
        wr(6'h00, 32'h0);
        wr(6'h00, 32'hFF00_0006);
        wr(6'h04, 32'h0400_0006);
        wr(6'h08, 32'h0000_0006);
        wr(6'h0C, 32'h3700_0006);
        rd(6'h00, v); chk("R4 ctl0 select reads 0", v, 32'h0000_0006);
        rd(6'h04, v); chk("R3 ctl1 fields", v, 32'h0400_0006);
        idle(50);
        rd(6'h28, v); chk("R5 code 0 counts nothing", v, 32'h0);
        rd(6'h2C, v); chk("R5 code beyond bus counts nothing", v, 32'h0);
        rd(6'h24, v);
        rd(6'h20, v);

        // R7 general clear
        wr(6'h04, 32'h0400_0004);
        rd(6'h04, v); chk("R7 clear bit reads 1", v, 32'h0400_0006);
        rd(6'h24, v);
        wr(6'h04, 32'h0400_0006);
        rd(6'h24, v);

        // R11 counter 0 disable freezes the bank
        wr(6'h00, 32'h0000_0002);
        rd(6'h24, a);
        idle(20);
        rd(6'h24, b); chk("R11 frozen cnt1", b, a);
        rd(6'h20, v);
        wr(6'h00, 32'h0000_0006);
        idle(20);
        rd(6'h24, v);
        rd(6'h20, v);

        // R12 value writes ignored, R2 unmapped
        rd(6'h24, a);
        wr(6'h24, 32'h0000_00FF);
        rd(6'h24, v);
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, v); chk("R2 unmapped reads 0", v, 32'h0);
        rd(6'h06, v); chk("R2 misaligned reads 0", v, 32'h0);

        // R8 cycle counter overflow
        for (int i = 0; i < 600 && !irq; i++) @(negedge clk);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);
        rd(6'h00, v); chk("R8 ovf bit", v, 32'h0000_0007);
        rd(6'h20, v); chk("R8 cnt0 wrapped", v, 32'h0);
        rd(6'h24, a);
        idle(30);
        rd(6'h24, b); chk("R8 cnt1 frozen", b, a);

        // R9 interrupt held until 0-then-1 clear
        wr(6'h00, 32'h0000_0004);
        @(negedge clk);
        chk("R9 irq held after clr=0", {31'b0, irq}, 32'h1);
        wr(6'h00, 32'h0000_0006);
        chk("R6 irq dropped after clear", {31'b0, irq}, 32'h0);
        rd(6'h20, v);

        // R10 silent wrap of a general counter
        evt_mode = 1;
        wr(6'h08, 32'h0500_0004);
        irq_seen = 0;
        for (int r = 0; r < 6; r++) begin
            idle(90);
            rd(6'h28, v);
            wr(6'h00, 32'h0000_0004);
            wr(6'h00, 32'h0000_0006);
        end
        rd(6'h28, v);
        chk("R10 no irq from general wrap", {31'b0, irq_seen}, 32'h0);
        evt_mode = 0;
        idle(5);
        finish_run();
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule